// File: doc/BRIEF.md
# Synchronous Serial Clock Output Generator

This block drives the clock pin of a UART that runs in synchronous mode. The transmitter sends a strobe at the start of every bit period of a frame. With the strobe it says whether the bit is a data bit and whether it is the last data bit of the frame. For each qualifying data bit the generator emits exactly one clock pulse. Between pulses, and during start bits, stop bits and idle periods, the pin rests at a programmable idle level.

The pulse width is set by a 5-bit divide value. The pin holds its active (non-idle) level for that many system clocks. A phase control picks which of the two pulse edges the receiver should sample on, and the block raises a one-cycle sample strobe for the receiver in the cycle where that edge appears on the pin. A separate control decides whether the last data bit of a frame carries a pulse. The bit period supplied by the transmitter must be at least one system clock longer than the active half of the pulse.

Top module: `uart_sclk_gen`

## Requirements
- R1: After reset `sclk_o` equals `cpol_i` and `sample_o` is 0.
- R2: With no accepted strobe, `sclk_o` holds `cpol_i` (idle high when 1, idle low when 0).
- R3: A `bit_stb_i` with `bit_is_data_i`=1 while enabled and idle drives `sclk_o` to `!cpol_i` from the next cycle for exactly N cycles, where N is the value of `div_i`, and then back to `cpol_i`.
- R4: A `div_i` of 0 behaves as N=1.
- R5: A strobe with `bit_is_data_i`=0 (start, stop or idle bit) produces no pulse and no sample strobe.
- R6: A strobe with `bit_is_last_i`=1 produces a pulse only when `last_pulse_en_i`=1. Otherwise the pin stays idle.
- R7: With `cpha_i`=0, `sample_o` is high for one cycle: the first cycle of the pulse, when the first edge appears.
- R8: With `cpha_i`=1, `sample_o` is high for one cycle: the cycle in which the pin returns to idle, when the second edge appears.
- R9: `sclk_oe_o` follows `sync_en_i`. While `sync_en_i`=0 no pulse is started and any pulse in progress ends at once.
- R10: A strobe that arrives while a pulse is in progress is ignored, so each bit gives at most one pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| sync_en_i | input | 1 | Synchronous mode / clock pin enable |
| div_i | input | 5 | Active half width in system clocks (0 treated as 1) |
| cpol_i | input | 1 | Idle level of the clock pin |
| cpha_i | input | 1 | 0: sample on first edge, 1: sample on second edge |
| last_pulse_en_i | input | 1 | Emit a pulse on the last data bit |
| bit_stb_i | input | 1 | One-cycle strobe at the start of each bit period |
| bit_is_data_i | input | 1 | The current bit is a data bit |
| bit_is_last_i | input | 1 | The current bit is the last data bit |
| sclk_o | output | 1 | Clock pin level |
| sclk_oe_o | output | 1 | Clock pin output enable |
| sample_o | output | 1 | One-cycle sample strobe for the receiver |

## Verification
The bench measures every pulse by counting the active cycles and recording the cycle position of the sample strobe. An off-by-one in the divider would show up as a pulse one cycle too wide or too narrow. A design that treats a divide value of zero literally would give either no pulse or a 32-cycle pulse. A swapped phase decode would put the strobe at the wrong edge. The bench also sends strobes that should be ignored: non-data bits, the last bit with its pulse disabled, a strobe while disabled, and a second strobe during a pulse. A design that gets any of these wrong would add pulses or stretch one.

// File: rtl/uart_sclk_pkg.sv
package uart_sclk_pkg;
  typedef enum logic {
    SEQ_IDLE  = 1'b0,
    SEQ_PULSE = 1'b1
  } seq_state_e;
endpackage

// File: rtl/uart_sclk_timer.sv
module uart_sclk_timer #(
  parameter int unsigned DIV_W = 5
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             load_i,
  input  logic             run_i,
  input  logic [DIV_W-1:0] div_i,
  output logic             done_o
);
  localparam logic [DIV_W-1:0] ONE = DIV_W'(1);

  logic [DIV_W-1:0] cnt_q;
  logic [DIV_W-1:0] div_eff;

  assign div_eff = (div_i == '0) ? ONE : div_i;
  assign done_o  = (cnt_q == '0);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
    end else if (load_i) begin
      cnt_q <= div_eff - ONE;
    end else if (run_i && cnt_q != '0) begin
      cnt_q <= cnt_q - ONE;
    end
  end

  // zero divide gives a single-cycle half
  assert_div_zero_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_i && div_i == '0 |=> done_o);
endmodule

// File: rtl/uart_sclk_seq.sv
module uart_sclk_seq
  import uart_sclk_pkg::*;
(
  input  logic clk_i,
  input  logic rst_ni,
  input  logic en_i,
  input  logic stb_i,
  input  logic is_data_i,
  input  logic is_last_i,
  input  logic last_pulse_en_i,
  input  logic done_i,
  output logic load_o,
  output logic active_o,
  output logic finish_o
);
  seq_state_e state_q, state_d;
  logic       want_pulse;

  assign want_pulse = stb_i && is_data_i && (!is_last_i || last_pulse_en_i);
  assign active_o   = (state_q == SEQ_PULSE);
  assign load_o     = en_i && !active_o && want_pulse;
  assign finish_o   = en_i && active_o && done_i;

  always_comb begin
    state_d = state_q;
    if (!en_i)              state_d = SEQ_IDLE;
    else if (load_o)        state_d = SEQ_PULSE;
    else if (finish_o)      state_d = SEQ_IDLE;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) state_q <= SEQ_IDLE;
    else         state_q <= state_d;
  end

  assert_hold_width_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    active_o && !done_i && en_i |=> active_o);
  assert_no_start_bit_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !active_o && stb_i && !is_data_i |=> !active_o);
  assert_last_gated_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !active_o && stb_i && is_last_i && !last_pulse_en_i |=> !active_o);
  assert_disable_stops_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i |=> !active_o);
endmodule

// File: rtl/uart_sclk_out.sv
module uart_sclk_out (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic en_i,
  input  logic cpol_i,
  input  logic cpha_i,
  input  logic active_i,
  input  logic load_i,
  input  logic finish_i,
  output logic sclk_o,
  output logic sclk_oe_o,
  output logic sample_o
);
  logic sample_q;

  // strobe lands in the cycle the chosen edge shows on the pin
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sample_q <= 1'b0;
    else         sample_q <= en_i && ((load_i && !cpha_i) || (finish_i && cpha_i));
  end

  assign sclk_o    = cpol_i ^ active_i;
  assign sclk_oe_o = en_i;
  assign sample_o  = sample_q;

  assert_sample_single_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sample_o |=> !sample_o);
  assert_sample_second_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(sample_o) && cpha_i && $stable(cpha_i) |-> !active_i);
endmodule

// File: rtl/uart_sclk_gen.sv
module uart_sclk_gen #(
  parameter int unsigned DIV_W = 5
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             sync_en_i,
  input  logic [DIV_W-1:0] div_i,
  input  logic             cpol_i,
  input  logic             cpha_i,
  input  logic             last_pulse_en_i,
  input  logic             bit_stb_i,
  input  logic             bit_is_data_i,
  input  logic             bit_is_last_i,
  output logic             sclk_o,
  output logic             sclk_oe_o,
  output logic             sample_o
);
  logic load, active, finish, done;

  uart_sclk_seq u_seq (
    .clk_i          (clk_i),
    .rst_ni         (rst_ni),
    .en_i           (sync_en_i),
    .stb_i          (bit_stb_i),
    .is_data_i      (bit_is_data_i),
    .is_last_i      (bit_is_last_i),
    .last_pulse_en_i(last_pulse_en_i),
    .done_i         (done),
    .load_o         (load),
    .active_o       (active),
    .finish_o       (finish)
  );

  uart_sclk_timer #(.DIV_W(DIV_W)) u_timer (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .load_i(load),
    .run_i (active),
    .div_i (div_i),
    .done_o(done)
  );

  uart_sclk_out u_out (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .en_i     (sync_en_i),
    .cpol_i   (cpol_i),
    .cpha_i   (cpha_i),
    .active_i (active),
    .load_i   (load),
    .finish_i (finish),
    .sclk_o   (sclk_o),
    .sclk_oe_o(sclk_oe_o),
    .sample_o (sample_o)
  );

  // R10: a second strobe mid-pulse must not reload the width
  assert_busy_ignore_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    active && !finish && sync_en_i |-> !load);
endmodule

// File: tb/uart_sclk_gen_test.sv
`timescale 1ns/1ps
module uart_sclk_gen_test;
  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic       sync_en_i = 1'b0;
  logic [4:0] div_i = '0;
  logic       cpol_i = 1'b0;
  logic       cpha_i = 1'b0;
  logic       last_pulse_en_i = 1'b0;
  logic       bit_stb_i = 1'b0;
  logic       bit_is_data_i = 1'b0;
  logic       bit_is_last_i = 1'b0;
  logic       sclk_o, sclk_oe_o, sample_o;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  always #2 clk_i = ~clk_i;

  uart_sclk_gen uut (
    .clk_i(clk_i), .rst_ni(rst_ni), .sync_en_i(sync_en_i), .div_i(div_i),
    .cpol_i(cpol_i), .cpha_i(cpha_i), .last_pulse_en_i(last_pulse_en_i),
    .bit_stb_i(bit_stb_i), .bit_is_data_i(bit_is_data_i),
    .bit_is_last_i(bit_is_last_i), .sclk_o(sclk_o), .sclk_oe_o(sclk_oe_o),
    .sample_o(sample_o)
  );

  task automatic check(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // strobe at one negedge, then observe 40 cycles; index 0 = first cycle after strobe
  task automatic run_bit(input int div, input bit pol, input bit pha, input bit data,
                         input bit last, input bit lpe, input int restrike,
                         output int act_cyc, output int samp_cnt, output int samp_idx);
    @(negedge clk_i);
    div_i = 5'(div); cpol_i = pol; cpha_i = pha; last_pulse_en_i = lpe;
    bit_is_data_i = data; bit_is_last_i = last; bit_stb_i = 1'b1;
    @(negedge clk_i);
    bit_stb_i = 1'b0;
    act_cyc = 0; samp_cnt = 0; samp_idx = -1;
    for (int i = 0; i < 40; i++) begin
      if (sclk_o != pol) act_cyc++;
      if (sample_o) begin samp_cnt++; samp_idx = i; end
      @(negedge clk_i);
      bit_stb_i = (i == restrike);
    end
    bit_stb_i = 1'b0;
  endtask

  task automatic t_pulse(string req, int div, bit pol, bit pha);
    int a, c, x, n;
    n = (div == 0) ? 1 : div;
    run_bit(div, pol, pha, 1, 0, 0, -1, a, c, x);
    check({req, " width"}, a, n);
    check({req, " sample count"}, c, 1);
    check({req, " sample position"}, x, pha ? n : 0);
  endtask

  task automatic t_reset;
    check("R1 sclk idle after reset", sclk_o, 0);
    check("R1 sample low after reset", sample_o, 0);
  endtask

  task automatic t_idle;
    sync_en_i = 1'b1;
    @(negedge clk_i); cpol_i = 1'b1;
    repeat (3) @(negedge clk_i);
    check("R2 idle high", sclk_o, 1);
    cpol_i = 1'b0;
    repeat (3) @(negedge clk_i);
    check("R2 idle low", sclk_o, 0);
  endtask

  task automatic t_non_data;
    int a, c, x;
    run_bit(6, 1, 0, 0, 0, 1, -1, a, c, x);
    check("R5 start/stop no pulse", a, 0);
    check("R5 start/stop no sample", c, 0);
  endtask

  task automatic t_last;
    int a, c, x;
    run_bit(4, 0, 0, 1, 1, 0, -1, a, c, x);
    check("R6 last bit gated off", a, 0);
    check("R6 last bit gated no sample", c, 0);
    run_bit(4, 0, 1, 1, 1, 1, -1, a, c, x);
    check("R6 last bit enabled width", a, 4);
    check("R6 last bit enabled sample", x, 4);
  endtask

  task automatic t_disabled;
    int a, c, x;
    sync_en_i = 1'b0;
    run_bit(5, 0, 0, 1, 0, 0, -1, a, c, x);
    check("R9 disabled oe", sclk_oe_o, 0);
    check("R9 disabled no pulse", a, 0);
    check("R9 disabled no sample", c, 0);
    sync_en_i = 1'b1;
    @(negedge clk_i);
    check("R9 enabled oe", sclk_oe_o, 1);
  endtask

  task automatic t_abort;
    int a;
    @(negedge clk_i);
    div_i = 5'd10; cpol_i = 1'b0; cpha_i = 1'b1; bit_is_data_i = 1'b1;
    bit_is_last_i = 1'b0; bit_stb_i = 1'b1;
    @(negedge clk_i); bit_stb_i = 1'b0;
    repeat (3) @(negedge clk_i);
    sync_en_i = 1'b0;
    @(negedge clk_i);
    a = 0;
    for (int i = 0; i < 12; i++) begin
      if (sclk_o) a++;
      @(negedge clk_i);
    end
    check("R9 disable ends pulse", a, 0);
    sync_en_i = 1'b1;
    @(negedge clk_i);
  endtask

  task automatic t_busy;
    int a, c, x;
    run_bit(8, 0, 0, 1, 0, 0, 3, a, c, x);
    check("R10 restrike width", a, 8);
    check("R10 restrike samples", c, 1);
  endtask

  initial begin
    repeat (3) @(negedge clk_i);
    t_reset();
    rst_ni = 1'b1;
    t_idle();
    t_pulse("R3 R7 div5 pol0 pha0", 5, 0, 0);
    t_pulse("R3 R8 div12 pol1 pha1", 12, 1, 1);
    t_pulse("R3 R7 div31 pol1 pha0", 31, 1, 0);
    t_pulse("R4 div0 pha0", 0, 0, 0);
    t_pulse("R4 div0 pha1", 0, 1, 1);
    t_pulse("R3 R8 div1 pol0 pha1", 1, 0, 1);
    t_non_data();
    t_last();
    t_disabled();
    t_abort();
    t_busy();
    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (20000) @(posedge clk_i);
        checks++; failures++;
        $display("FAIL watchdog: actual=timeout expected=completion");
      end
    join_any
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule